// File: doc/BRIEF.md
# Ethernet PHY Management Register Responder

This block stands in for the management register set of an Ethernet transceiver. A management controller sends it one request at a time. Each request carries a PHY address, a register number, a read/write flag and, for writes, a data word. The block holds thirty-two 16-bit registers. It answers only the PHY address it is configured for. A read aimed at any other address gets the all-ones word that an undriven management bus would return.

Four register numbers are not read back from storage. The basic status word, the link partner ability word, the speed word and the diagnostic word are built when the read is accepted. They are derived from a `link_up` input and from the stored advertisement register. This makes the responder look like a PHY that always finishes autonegotiation and agrees with whatever the controller advertises. All other register numbers read back their stored contents.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 reads 0x01E1, and other stored registers (for example register 9) read 0x0000.
- R2: An accepted request (`req_valid` and `req_ready` both high at a clock edge) produces `rsp_valid` high for exactly the next cycle. `req_ready` is low in that cycle and high otherwise. After reset `req_ready` is high and `rsp_valid` is low. A write response carries `rsp_rdata` = 0x0000.
- R3: A read of register 1 returns 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) when `link_up` is high at acceptance, and 0x0000 when it is low.
- R4: A read of register 5 returns 0x4001 ORed with bits 8:5 of register 4, whatever the link state.
- R5: A read of register 17 returns 0x8000, whatever the link state.
- R6: A read of register 18 returns 0x0000 when the link is down. When the link is up, bit 10 is register 4 bit 7 OR bit 8, bit 11 is register 4 bit 8 OR bit 6, and all other bits are zero.
- R7: A write to the configured PHY address stores its data in the addressed register. A later read of a stored register returns that data.
- R8: Every accepted write to the configured address leaves bit 15 of register 0 cleared, including a write of 0x8000 or more to register 0 itself.
- R9: A read aimed at any PHY address other than `PHY_ADDR` (default 7) returns 0xFFFF. A write aimed at another address changes no register.
- R10: Only the low 5 bits of `req_reg` select the register. Register numbers 0x29 and 0x09 name the same register.
- R11: Writes to registers 1, 5, 17 and 18 do not change what those registers return on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | REQ_REG_W (8) | Register number; low 5 bits used |
| req_wdata | input | 16 | Write data |
| link_up | input | 1 | Link state used for the computed status words |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | 16 | Read data (0 for writes) |

## Verification
A stored register that is corrupted, for example a lost reset value or a bit 15 of register 0 left set, shows up in the response word one cycle after the next read of that register. It stays hidden until that read. An error in the computed words or in the address match is seen on the first response that follows the relevant request. A fault in the handshake shows at once as a response that is missing or doubled, or as `req_ready` high while a response is pending. The scoreboard catches any of these as a mismatch or as a queue left uneven.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 5;
    localparam int PHY_W  = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [PHY_W-1:0]  phy_t;

    localparam idx_t IDX_CTRL    = 5'd0;
    localparam idx_t IDX_STATUS  = 5'd1;
    localparam idx_t IDX_ADVERT  = 5'd4;
    localparam idx_t IDX_PARTNER = 5'd5;
    localparam idx_t IDX_SPEED   = 5'd17;
    localparam idx_t IDX_DIAG    = 5'd18;

    localparam word_t STATUS_UP     = 16'h782E;
    localparam word_t PARTNER_BASE  = 16'h4001;
    localparam word_t PARTNER_MASK  = 16'h01E0;
    localparam word_t SPEED_WORD    = 16'h8000;
    localparam word_t ABSENT_WORD   = 16'hFFFF;
    localparam word_t CTRL_KEEP     = 16'h7FFF;

    typedef struct packed {
        logic  wr;
        phy_t  phy;
        idx_t  idx;
        word_t data;
    } mgmt_req_t;

    function automatic word_t reset_word(input int unsigned i);
        case (i)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic word_t diag_word(input word_t adv, input logic link);
        word_t w;
        w = '0;
        if (link) begin
            w[10] = adv[7] | adv[8];
            w[11] = adv[8] | adv[6];
        end
        return w;
    endfunction

endpackage

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  word_t wr_data,
    input  idx_t  rd_idx,
    output word_t rd_data,
    output word_t adv_word
);

    localparam int NUM_REGS = 1 << IDX_W;

    word_t regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= reset_word(g);
                end else if (wr_en) begin
                    regs[g] <= ((wr_idx == idx_t'(g)) ? wr_data : regs[g]) & CTRL_KEEP;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= reset_word(g);
                end else if (wr_en && wr_idx == idx_t'(g)) begin
                    regs[g] <= wr_data;
                end
            end
        end
    end

    assign rd_data  = regs[rd_idx];
    assign adv_word = regs[IDX_ADVERT];

endmodule

// File: rtl/phy_mgmt_readmux.sv
module phy_mgmt_readmux
    import phy_mgmt_pkg::*;
(
    input  idx_t  idx,
    input  logic  addr_hit,
    input  logic  link_up,
    input  word_t stored,
    input  word_t adv_word,
    output word_t rd_word
);

    always_comb begin
        unique case (idx)
            IDX_STATUS:  rd_word = link_up ? STATUS_UP : '0;
            IDX_PARTNER: rd_word = PARTNER_BASE | (adv_word & PARTNER_MASK);
            IDX_SPEED:   rd_word = SPEED_WORD;
            IDX_DIAG:    rd_word = diag_word(adv_word, link_up);
            default:     rd_word = stored;
        endcase
        if (!addr_hit) begin
            rd_word = ABSENT_WORD;
        end
    end

endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
    import phy_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR  = 5'd7,
    parameter int         REQ_REG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [4:0]           req_phy,
    input  logic [REQ_REG_W-1:0] req_reg,
    input  logic [15:0]          req_wdata,
    input  logic                 link_up,
    output logic                 rsp_valid,
    output logic [15:0]          rsp_rdata
);

    mgmt_req_t req;
    logic      accept;
    logic      addr_hit;
    word_t     stored;
    word_t     adv_word;
    word_t     rd_word;

    assign req = '{wr: req_write, phy: req_phy, idx: req_reg[IDX_W-1:0], data: req_wdata};

    assign req_ready = !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign addr_hit  = (req.phy == PHY_ADDR);

    phy_mgmt_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept && req.wr && addr_hit),
        .wr_idx   (req.idx),
        .wr_data  (req.data),
        .rd_idx   (req.idx),
        .rd_data  (stored),
        .adv_word (adv_word)
    );

    phy_mgmt_readmux u_mux (
        .idx      (req.idx),
        .addr_hit (addr_hit),
        .link_up  (link_up),
        .stored   (stored),
        .adv_word (adv_word),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_rdata <= req.wr ? '0 : rd_word;
            end
        end
    end

endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
    parameter logic [4:0] PHY_ADDR  = 5'd7,
    parameter int         REQ_REG_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [4:0]           req_phy,
    input logic [REQ_REG_W-1:0] req_reg,
    input logic                 link_up,
    input logic                 rsp_valid,
    input logic [15:0]          rsp_rdata
);

    logic acc;
    logic rd_hit;
    assign acc    = req_valid && req_ready;
    assign rd_hit = acc && !req_write && req_phy == PHY_ADDR;

    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);  // R2
    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc));  // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);  // R2
    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write) |=> rsp_rdata == 16'h0000);  // R2
    AST_STATUS_LINK_DOWN: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && req_reg[4:0] == 5'd1 && !link_up) |=> rsp_rdata == 16'h0000);  // R3
    AST_STATUS_LINK_UP: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && req_reg[4:0] == 5'd1 && link_up) |=> rsp_rdata == 16'h782E);  // R3
    AST_SPEED_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && req_reg[4:0] == 5'd17) |=> rsp_rdata == 16'h8000);  // R5
    AST_DIAG_LINK_DOWN: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && req_reg[4:0] == 5'd18 && !link_up) |=> rsp_rdata == 16'h0000);  // R6
    AST_CTRL_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && req_reg[4:0] == 5'd0) |=> !rsp_rdata[15]);  // R8
    AST_FOREIGN_ONES: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && req_phy != PHY_ADDR) |=> rsp_rdata == 16'hFFFF);  // R9

endmodule

bind phy_mgmt_responder phy_mgmt_checker #(
    .PHY_ADDR  (PHY_ADDR),
    .REQ_REG_W (REQ_REG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .link_up   (link_up),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/phy_mgmt_responder_bench.sv
module phy_mgmt_responder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = 5'd0;
    logic [7:0]  req_reg = 8'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        link_up = 1'b1;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    phy_mgmt_responder u_phy_mgmt_responder (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .link_up   (link_up),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // driver: called at a falling edge; returns at the falling edge after acceptance
    task automatic issue(input logic wr, input logic [4:0] phy, input logic [7:0] regn,
                         input logic [15:0] data, input logic [15:0] exp, input string tag);
        req_valid = 1'b1;
        req_write = wr;
        req_phy   = phy;
        req_reg   = regn;
        req_wdata = data;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] regn, input logic [15:0] exp, input string tag);
        issue(1'b0, 5'd7, regn, 16'h0, exp, tag);
    endtask

    task automatic wr(input logic [7:0] regn, input logic [15:0] data, input string tag);
        issue(1'b1, 5'd7, regn, data, 16'h0000, tag);
    endtask

    // monitor: pops one expected word per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            check(!req_ready, "R2 ready low during response", {15'd0, req_ready}, 16'h0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", rsp_rdata, 16'h0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0, "R2 idle after reset",
              {14'd0, req_ready, rsp_valid}, 16'h0002);

        rd(8'd0,  16'h3100, "R1 reg0 reset");
        rd(8'd2,  16'h0300, "R1 reg2 reset");
        rd(8'd3,  16'hE400, "R1 reg3 reset");
        rd(8'd4,  16'h01E1, "R1 reg4 reset");
        rd(8'd9,  16'h0000, "R1 reg9 reset");

        rd(8'd1,  16'h782E, "R3 status link up");
        rd(8'd5,  16'h41E1, "R4 partner default");
        rd(8'd17, 16'h8000, "R5 speed link up");
        rd(8'd18, 16'h0C00, "R6 diag default");
        link_up = 1'b0;
        rd(8'd1,  16'h0000, "R3 status link down");
        rd(8'd17, 16'h8000, "R5 speed link down");
        rd(8'd18, 16'h0000, "R6 diag link down");
        rd(8'd5,  16'h41E1, "R4 partner link down");
        link_up = 1'b1;

        wr(8'd4, 16'h0041, "R2 write rsp");
        rd(8'd18, 16'h0800, "R6 diag adv bit6");
        rd(8'd5,  16'h4041, "R4 partner adv bit6");
        wr(8'd4, 16'h0080, "R2 write rsp");
        rd(8'd18, 16'h0400, "R6 diag adv bit7");
        rd(8'd5,  16'h4081, "R4 partner adv bit7");
        wr(8'd4, 16'h0100, "R2 write rsp");
        rd(8'd18, 16'h0C00, "R6 diag adv bit8");
        rd(8'd5,  16'h4101, "R4 partner adv bit8");

        wr(8'd9, 16'hBEEF, "R2 write rsp");
        rd(8'd9, 16'hBEEF, "R7 reg9 readback");
        wr(8'd0, 16'h8123, "R2 write rsp");
        rd(8'd0, 16'h0123, "R8 reg0 bit15 cleared");
        wr(8'd9, 16'h1111, "R2 write rsp");
        rd(8'd0, 16'h0123, "R8 reg0 after other write");

        wr(8'd17, 16'h1234, "R2 write rsp");
        rd(8'd17, 16'h8000, "R11 reg17 unchanged");
        wr(8'd1, 16'h0000, "R2 write rsp");
        rd(8'd1, 16'h782E, "R11 reg1 unchanged");

        issue(1'b0, 5'd3, 8'd9, 16'h0, 16'hFFFF, "R9 foreign read");
        issue(1'b0, 5'd8, 8'd0, 16'h0, 16'hFFFF, "R9 foreign read reg0");
        issue(1'b1, 5'd3, 8'd9, 16'h5555, 16'h0000, "R2 write rsp");
        rd(8'd9, 16'h1111, "R9 foreign write ignored");

        rd(8'h29, 16'h1111, "R10 upper bits ignored read");
        wr(8'h64, 16'h01E1, "R2 write rsp");
        rd(8'd4, 16'h01E1, "R10 upper bits ignored write");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all responses seen", 16'(exp_q.size()), 16'h0);
        summary();
        $finish;
    end

endmodule